// File: doc/BRIEF.md
# Bridge Parity Error Response Controller

This block decides how a two-sided bus bridge reacts when a data phase on its primary bus carries bad parity. Each accepted data phase is presented with a transaction class, a parity-error strobe and the initiator's multi-phase request. The block combines these with the primary and secondary parity-response enables and returns four things. It gives a registered forward-or-drop verdict. It requests target ready and stop for writes it absorbs. It flags read data that must be handed on with bad parity. It drives the primary error line (PERR#, active low) and sets two sticky status flags: a detected flag and a reported flag.

For upstream writes the bridge is the initiator on the primary side, so it watches the primary error line that the far target drives. When reporting is enabled on both sides, it carries that error to the secondary initiator. The relayed error appears on the secondary error line in the cycle the bridge hands back target ready on that side. Parity generation, queue storage and arbitration sit outside the block.

Top module: `bridge_perr_ctrl`

## Requirements
- R1: After reset both status flags read 0, both error outputs read 1 (idle), and the verdict, ready, stop and poison outputs read 0.
- R2: Every accepted data phase produces `dec_vld`=1 in the next cycle only. A phase without a parity error gives `dec_drop`=0, `rd_poison`=0 and no status change.
- R3: Class 0 (downstream write) with a parity error and `per_pri_en`=0 is forwarded (`dec_drop`=0, no ready/stop request). `sts_ped` is set and `pri_perr_n` stays 1.
- R4: Class 0 with a parity error and `per_pri_en`=1 gives `dec_drop`=1 and `tgt_trdy_req`=1 in the next cycle. `tgt_stop_req` equals `dp_multi` in that cycle. `sts_ped` is set.
- R5: An error reported on the primary error line drives `pri_perr_n` low exactly two cycles after the errored phase, for one cycle per errored phase. Back-to-back errored phases give back-to-back low cycles. Status flags read 1 from that same cycle.
- R6: Class 3 (upstream read) with a parity error gives `rd_poison`=1 in the next cycle and sets `sts_ped` regardless of enables. Only with `per_pri_en`=1 does it also set `sts_dpd` and drive `pri_perr_n` low.
- R7: Class 4 (configuration/CSR write) with a parity error is kept (`dec_drop`=0) and sets `sts_ped`. `pri_perr_n` goes low only when `per_pri_en`=1.
- R8: Classes 2 (downstream read) and 5 (configuration/CSR read) with a parity error change no status flag and drive no error line. They give no poison and no drop.
- R9: For class 1 (upstream write), `pri_perr_obs_n` is sampled two cycles after the phase. If it is low and `per_pri_en`=1, `sts_dpd` reads 1 one cycle later. With `per_pri_en`=0 it stays 0. Class 1 never sets `sts_ped`.
- R10: When R9 sets `sts_dpd` while `per_sec_en`=1, a relay is armed. `sec_perr_n` is low in the first later cycle with `sec_trdy_ret`=1, and only then. With `per_sec_en`=0 it stays 1.
- R11: Each status flag holds until its clear input pulses. A set event and a clear in the same cycle leave the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_valid | input | 1 | A data phase is accepted this cycle |
| dp_class | input | 3 | Transaction class: 0 DS write, 1 US write, 2 DS read, 3 US read, 4 cfg write, 5 cfg read |
| dp_par_err | input | 1 | Parity error seen on this data phase |
| dp_multi | input | 1 | Initiator requested several data phases |
| per_pri_en | input | 1 | Primary parity-response enable |
| per_sec_en | input | 1 | Secondary parity-response enable |
| pri_perr_obs_n | input | 1 | Observed primary error line, active low |
| sec_trdy_ret | input | 1 | Bridge returns target ready on the secondary side |
| clr_ped | input | 1 | Write-one-to-clear pulse for the detected flag |
| clr_dpd | input | 1 | Write-one-to-clear pulse for the reported flag |
| sts_ped | output | 1 | Sticky parity-error-detected flag |
| sts_dpd | output | 1 | Sticky data-parity-reported flag |
| pri_perr_n | output | 1 | Primary error line drive, active low |
| sec_perr_n | output | 1 | Secondary error line drive, active low |
| dec_vld | output | 1 | Verdict valid for the phase accepted last cycle |
| dec_drop | output | 1 | Verdict: do not forward the write |
| tgt_trdy_req | output | 1 | Request target ready to the initiator |
| tgt_stop_req | output | 1 | Request stop together with target ready |
| rd_poison | output | 1 | Returned read data must carry bad parity |

## Verification
The properties assume the enables are stable for at least two cycles around each data phase. They also assume `dp_class` is one of the six defined codes while `dp_valid` is high, and that `sec_trdy_ret` is not raised in the very cycle a relay is being armed. The directed stimulus changes enables only while the block is idle. It drives only defined classes and raises secondary ready only after the reported flag has been read back, so the checker's timing relations between a phase and its error-line and status effects stay within these assumptions.

// File: rtl/bperr_pkg.sv
package bperr_pkg;
  localparam int CLS_W = 3;
  localparam int STS_N = 2;
  localparam int STS_PED = 0;
  localparam int STS_DPD = 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_DSW = 3'd0,
    CLS_USW = 3'd1,
    CLS_DSR = 3'd2,
    CLS_USR = 3'd3,
    CLS_CFW = 3'd4,
    CLS_CFR = 3'd5
  } xact_cls_e;

  typedef struct packed {
    logic vld;
    logic drop;
    logic trdy;
    logic stop;
    logic poison;
    logic ped;
    logic dpd;
    logic perr;
  } resp_t;
endpackage

// File: rtl/bperr_decode.sv
module bperr_decode
  import bperr_pkg::*;
(
  input  logic             dp_valid,
  input  logic [CLS_W-1:0] dp_class,
  input  logic             dp_par_err,
  input  logic             dp_multi,
  input  logic             pri_en,
  output resp_t            resp
);
  xact_cls_e cls;

  always_comb begin
    cls  = xact_cls_e'(dp_class);
    resp = '0;
    if (dp_valid) begin
      resp.vld = 1'b1;
      if (dp_par_err) begin
        case (cls)
          CLS_DSW: begin
            resp.ped = 1'b1;
            if (pri_en) begin
              resp.drop = 1'b1;
              resp.trdy = 1'b1;
              resp.stop = dp_multi;
              resp.perr = 1'b1;
            end
          end
          CLS_USR: begin
            resp.ped    = 1'b1;
            resp.poison = 1'b1;
            if (pri_en) begin
              resp.dpd  = 1'b1;
              resp.perr = 1'b1;
            end
          end
          CLS_CFW: begin
            resp.ped = 1'b1;
            if (pri_en) resp.perr = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/bperr_relay.sv
module bperr_relay
  import bperr_pkg::*;
#(
  parameter int OBS_LAT = 2
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             dp_valid,
  input  logic [CLS_W-1:0] dp_class,
  input  logic             pri_en,
  input  logic             sec_en,
  input  logic             obs_n,
  input  logic             sec_trdy_ret,
  output logic             dpd_set,
  output logic             sec_perr_n
);
  logic [OBS_LAT-1:0] win_q, win_d;
  logic               win_in, tap;
  logic               pend_q, pend_d, pend_en;

  assign win_in = dp_valid && (dp_class == CLS_USW);

  generate
    if (OBS_LAT == 1) begin : g_one
      always_comb win_d = win_in;
    end else begin : g_many
      always_comb win_d = {win_q[OBS_LAT-2:0], win_in};
    end
  endgenerate

  assign tap = win_q[OBS_LAT-1];

  always_comb begin
    dpd_set = tap && !obs_n && pri_en;
    pend_en = (dpd_set && sec_en) || (pend_q && sec_trdy_ret);
    pend_d  = dpd_set && sec_en;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign sec_perr_n = !(pend_q && sec_trdy_ret);
endmodule

// File: rtl/bperr_status.sv
module bperr_status #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] set_ev,
  input  logic [W-1:0] clr_ev,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q, flags_d, flags_en;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
        flags_en[i] = set_ev[i] || clr_ev[i];
        flags_d[i]  = set_ev[i];
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) begin
          flags_q[i] <= 1'b0;
        end else if (flags_en[i]) begin
          flags_q[i] <= flags_d[i];
        end
      end
    end
  endgenerate

  assign flags = flags_q;
endmodule

// File: rtl/bridge_perr_ctrl.sv
module bridge_perr_ctrl
  import bperr_pkg::*;
#(
  parameter int OBS_LAT    = 2,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_valid,
  input  logic [CLS_W-1:0] dp_class,
  input  logic             dp_par_err,
  input  logic             dp_multi,
  input  logic             per_pri_en,
  input  logic             per_sec_en,
  input  logic             pri_perr_obs_n,
  input  logic             sec_trdy_ret,
  input  logic             clr_ped,
  input  logic             clr_dpd,
  output logic             sts_ped,
  output logic             sts_dpd,
  output logic             pri_perr_n,
  output logic             sec_perr_n,
  output logic             dec_vld,
  output logic             dec_drop,
  output logic             tgt_trdy_req,
  output logic             tgt_stop_req,
  output logic             rd_poison
);
  logic [RST_STAGES-1:0] rs_q;
  logic                  srst_n;
  resp_t                 resp_d, resp_q;
  logic                  perr_n_q, perr_n_d;
  logic                  relay_dpd;
  logic [STS_N-1:0]      sts_set, sts_clr, sts_q;

  // reset: asserted asynchronously, released on a clock edge
  generate
    if (RST_STAGES == 1) begin : g_rs1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= 1'b1;
      end
    end else begin : g_rsn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign srst_n = rs_q[RST_STAGES-1];

  bperr_decode u_decode (
    .dp_valid   (dp_valid),
    .dp_class   (dp_class),
    .dp_par_err (dp_par_err),
    .dp_multi   (dp_multi),
    .pri_en     (per_pri_en),
    .resp       (resp_d)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) resp_q <= '0;
    else         resp_q <= resp_d;
  end

  always_comb perr_n_d = !resp_q.perr;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) perr_n_q <= 1'b1;
    else         perr_n_q <= perr_n_d;
  end

  bperr_relay #(.OBS_LAT(OBS_LAT)) u_relay (
    .clk          (clk),
    .srst_n       (srst_n),
    .dp_valid     (dp_valid),
    .dp_class     (dp_class),
    .pri_en       (per_pri_en),
    .sec_en       (per_sec_en),
    .obs_n        (pri_perr_obs_n),
    .sec_trdy_ret (sec_trdy_ret),
    .dpd_set      (relay_dpd),
    .sec_perr_n   (sec_perr_n)
  );

  always_comb begin
    sts_set          = '0;
    sts_clr          = '0;
    sts_set[STS_PED] = resp_q.ped;
    sts_set[STS_DPD] = resp_q.dpd || relay_dpd;
    sts_clr[STS_PED] = clr_ped;
    sts_clr[STS_DPD] = clr_dpd;
  end

  bperr_status #(.W(STS_N)) u_status (
    .clk    (clk),
    .srst_n (srst_n),
    .set_ev (sts_set),
    .clr_ev (sts_clr),
    .flags  (sts_q)
  );

  assign sts_ped      = sts_q[STS_PED];
  assign sts_dpd      = sts_q[STS_DPD];
  assign pri_perr_n   = perr_n_q;
  assign dec_vld      = resp_q.vld;
  assign dec_drop     = resp_q.drop;
  assign tgt_trdy_req = resp_q.trdy;
  assign tgt_stop_req = resp_q.stop;
  assign rd_poison    = resp_q.poison;
endmodule

module bridge_perr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_valid,
  input logic [2:0] dp_class,
  input logic       dp_par_err,
  input logic       sec_trdy_ret,
  input logic       clr_ped,
  input logic       clr_dpd,
  input logic       sts_ped,
  input logic       sts_dpd,
  input logic       pri_perr_n,
  input logic       sec_perr_n,
  input logic       dec_vld,
  input logic       dec_drop,
  input logic       tgt_trdy_req,
  input logic       tgt_stop_req,
  input logic       rd_poison
);
  // R4
  drop_needs_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_drop |-> (tgt_trdy_req && dec_vld));

  // R4
  stop_needs_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_stop_req |-> tgt_trdy_req);

  // R5
  perr_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_perr_n |-> $past(dp_valid && dp_par_err, 2));

  // R6
  poison_with_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poison |-> dec_vld);

  // R8
  read_side_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && (dp_class == 3'd2 || dp_class == 3'd5)) |=> (!rd_poison && !dec_drop));

  // R10
  sec_perr_on_trdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_perr_n |-> sec_trdy_ret);

  // R11
  ped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_ped && !clr_ped) |=> sts_ped);

  // R11
  dpd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_dpd && !clr_dpd) |=> sts_dpd);
endmodule

bind bridge_perr_ctrl bridge_perr_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dp_valid     (dp_valid),
  .dp_class     (dp_class),
  .dp_par_err   (dp_par_err),
  .sec_trdy_ret (sec_trdy_ret),
  .clr_ped      (clr_ped),
  .clr_dpd      (clr_dpd),
  .sts_ped      (sts_ped),
  .sts_dpd      (sts_dpd),
  .pri_perr_n   (pri_perr_n),
  .sec_perr_n   (sec_perr_n),
  .dec_vld      (dec_vld),
  .dec_drop     (dec_drop),
  .tgt_trdy_req (tgt_trdy_req),
  .tgt_stop_req (tgt_stop_req),
  .rd_poison    (rd_poison)
);

// File: tb/bridge_perr_ctrl_bench.sv
module bridge_perr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dp_valid, dp_par_err, dp_multi;
  logic [2:0] dp_class;
  logic       per_pri_en, per_sec_en, pri_perr_obs_n, sec_trdy_ret;
  logic       clr_ped, clr_dpd;
  logic       sts_ped, sts_dpd, pri_perr_n, sec_perr_n;
  logic       dec_vld, dec_drop, tgt_trdy_req, tgt_stop_req, rd_poison;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  bridge_perr_ctrl u_bridge_perr_ctrl (
    .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .dp_class(dp_class),
    .dp_par_err(dp_par_err), .dp_multi(dp_multi), .per_pri_en(per_pri_en),
    .per_sec_en(per_sec_en), .pri_perr_obs_n(pri_perr_obs_n),
    .sec_trdy_ret(sec_trdy_ret), .clr_ped(clr_ped), .clr_dpd(clr_dpd),
    .sts_ped(sts_ped), .sts_dpd(sts_dpd), .pri_perr_n(pri_perr_n),
    .sec_perr_n(sec_perr_n), .dec_vld(dec_vld), .dec_drop(dec_drop),
    .tgt_trdy_req(tgt_trdy_req), .tgt_stop_req(tgt_stop_req),
    .rd_poison(rd_poison)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // drive one phase; returns one cycle after acceptance
  task automatic phase(input logic [2:0] cls, input logic err, input logic multi);
    dp_valid = 1'b1; dp_class = cls; dp_par_err = err; dp_multi = multi;
    @(negedge clk);
    dp_valid = 1'b0; dp_par_err = 1'b0; dp_multi = 1'b0;
  endtask

  task automatic clear_all();
    clr_ped = 1'b1; clr_dpd = 1'b1;
    @(negedge clk);
    clr_ped = 1'b0; clr_dpd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "sts_ped", sts_ped, 1'b0);
    chk("R1", "sts_dpd", sts_dpd, 1'b0);
    chk("R1", "pri_perr_n", pri_perr_n, 1'b1);
    chk("R1", "sec_perr_n", sec_perr_n, 1'b1);
    chk("R1", "dec_vld", dec_vld, 1'b0);
    chk("R1", "tgt_trdy_req", tgt_trdy_req, 1'b0);
    chk("R1", "rd_poison", rd_poison, 1'b0);
  endtask

  task automatic t_no_error();
    per_pri_en = 1'b1;
    phase(3'd0, 1'b0, 1'b0);
    chk("R2", "dec_vld", dec_vld, 1'b1);
    chk("R2", "dec_drop", dec_drop, 1'b0);
    @(negedge clk);
    chk("R2", "dec_vld gone", dec_vld, 1'b0);
    chk("R2", "sts_ped", sts_ped, 1'b0);
    chk("R2", "pri_perr_n", pri_perr_n, 1'b1);
  endtask

  task automatic t_dsw_off();
    per_pri_en = 1'b0;
    phase(3'd0, 1'b1, 1'b1);
    chk("R3", "dec_drop", dec_drop, 1'b0);
    chk("R3", "tgt_trdy_req", tgt_trdy_req, 1'b0);
    @(negedge clk);
    chk("R3", "sts_ped", sts_ped, 1'b1);
    chk("R3", "pri_perr_n", pri_perr_n, 1'b1);
    clear_all();
    chk("R11", "ped after clear", sts_ped, 1'b0);
  endtask

  task automatic t_dsw_on(input logic multi);
    per_pri_en = 1'b1;
    phase(3'd0, 1'b1, multi);
    chk("R4", "dec_drop", dec_drop, 1'b1);
    chk("R4", "tgt_trdy_req", tgt_trdy_req, 1'b1);
    chk("R4", "tgt_stop_req", tgt_stop_req, multi);
    chk("R5", "pri_perr_n early", pri_perr_n, 1'b1);
    @(negedge clk);
    chk("R5", "pri_perr_n low", pri_perr_n, 1'b0);
    chk("R4", "sts_ped", sts_ped, 1'b1);
    @(negedge clk);
    chk("R5", "pri_perr_n released", pri_perr_n, 1'b1);
    clear_all();
  endtask

  task automatic t_burst();
    per_pri_en = 1'b1;
    dp_valid = 1'b1; dp_class = 3'd0; dp_par_err = 1'b1; dp_multi = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5", "burst low 1", pri_perr_n, 1'b0);
    @(negedge clk);
    dp_valid = 1'b0; dp_par_err = 1'b0; dp_multi = 1'b0;
    chk("R5", "burst low 2", pri_perr_n, 1'b0);
    @(negedge clk);
    chk("R5", "burst low 3", pri_perr_n, 1'b0);
    @(negedge clk);
    chk("R5", "burst end", pri_perr_n, 1'b1);
    clear_all();
  endtask

  task automatic t_usr(input logic en);
    per_pri_en = en;
    phase(3'd3, 1'b1, 1'b0);
    chk("R6", "rd_poison", rd_poison, 1'b1);
    chk("R6", "dec_drop", dec_drop, 1'b0);
    @(negedge clk);
    chk("R6", "sts_ped", sts_ped, 1'b1);
    chk("R6", "sts_dpd", sts_dpd, en);
    chk("R6", "pri_perr_n", pri_perr_n, !en);
    @(negedge clk);
    clear_all();
  endtask

  task automatic t_cfw(input logic en);
    per_pri_en = en;
    phase(3'd4, 1'b1, 1'b0);
    chk("R7", "dec_drop", dec_drop, 1'b0);
    @(negedge clk);
    chk("R7", "sts_ped", sts_ped, 1'b1);
    chk("R7", "pri_perr_n", pri_perr_n, !en);
    @(negedge clk);
    clear_all();
  endtask

  task automatic t_reads(input logic [2:0] cls);
    per_pri_en = 1'b1;
    phase(cls, 1'b1, 1'b0);
    chk("R8", "rd_poison", rd_poison, 1'b0);
    chk("R8", "dec_drop", dec_drop, 1'b0);
    @(negedge clk);
    chk("R8", "sts_ped", sts_ped, 1'b0);
    chk("R8", "sts_dpd", sts_dpd, 1'b0);
    chk("R8", "pri_perr_n", pri_perr_n, 1'b1);
  endtask

  task automatic t_usw(input logic pri, input logic sec);
    per_pri_en = pri; per_sec_en = sec;
    phase(3'd1, 1'b1, 1'b0);
    pri_perr_obs_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pri_perr_obs_n = 1'b1;
    chk("R9", "sts_dpd", sts_dpd, pri);
    chk("R9", "sts_ped", sts_ped, 1'b0);
    chk("R10", "sec_perr_n idle", sec_perr_n, 1'b1);
    sec_trdy_ret = 1'b1;
    #1;
    chk("R10", "sec_perr_n on trdy", sec_perr_n, !(pri && sec));
    @(negedge clk);
    chk("R10", "sec_perr_n once", sec_perr_n, 1'b1);
    sec_trdy_ret = 1'b0;
    clear_all();
  endtask

  task automatic t_same_cycle();
    per_pri_en = 1'b1;
    phase(3'd0, 1'b1, 1'b0);
    clr_ped = 1'b1;
    @(negedge clk);
    clr_ped = 1'b0;
    chk("R11", "set wins over clear", sts_ped, 1'b1);
    clr_ped = 1'b1;
    @(negedge clk);
    clr_ped = 1'b0;
    chk("R11", "clear alone", sts_ped, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dp_valid = 1'b0; dp_class = 3'd0; dp_par_err = 1'b0;
    dp_multi = 1'b0; per_pri_en = 1'b0; per_sec_en = 1'b0;
    pri_perr_obs_n = 1'b1; sec_trdy_ret = 1'b0; clr_ped = 1'b0; clr_dpd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_error();
    t_dsw_off();
    t_dsw_on(1'b0);
    t_dsw_on(1'b1);
    t_burst();
    t_usr(1'b0);
    t_usr(1'b1);
    t_cfw(1'b0);
    t_cfw(1'b1);
    t_reads(3'd2);
    t_reads(3'd5);
    t_usw(1'b1, 1'b1);
    t_usw(1'b1, 1'b0);
    t_usw(1'b0, 1'b1);
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule